// File: doc/BRIEF.md
# Configuration Frame Write Engine

This block sits behind a configuration packet decoder. It takes decoded write packets one data word per beat, keeps a small set of configuration registers, and decides when a fresh frame write begins. Words sent to the frame-data register are grouped into fixed-length frames. Each word is passed on with its frame address and its position inside the frame, and a completion pulse marks the last word of every whole frame. An identity word that does not match the expected device identifier raises a sticky invalid flag.

The frame address auto-increments through a parameterised list of valid address ranges. It jumps over the holes between the ranges, and it stays put when no later valid address exists. A write to the frame-address register normally re-arms the pending write command. A masked bit in the control register can suppress this, so that address writes can be inserted into the stream without restarting the write.

Top module: `cfg_frame_writer`

## Requirements
- R1: Only packets whose opcode is 2'b10 (write) have any effect. A packet with opcode 2'b00, 2'b01 or 2'b11 produces no `out_wr` and changes no register, the invalid flag included.
- R2: Register addresses are 1 = frame address, 2 = frame data, 4 = command, 6 = mask, 8 = control, 12 = identity. A packet to a register other than frame data that carries no data word is ignored. When such a packet carries words, only its first word is used.
- R3: A control write stores the incoming word ANDed with the mask register as it stands at that moment. The mask resets to zero.
- R4: A command write of value 1 stores the command and sets the pending-start flag.
- R5: A frame-address write loads the frame address register. It also sets the pending-start flag when control bit 21 is 0 and the command register holds 1.
- R6: When a frame-data packet starts with the pending-start flag set, the current frame address is loaded from the frame address register and the flag is cleared.
- R7: Each frame-data word appears on `out_wr` one cycle after its beat, together with the current frame address, the word index (0 to 100 with the default 101-word frame) and the word itself. `out_done` is high with index 100 only, and the address stays the same for the whole frame.
- R8: After each whole frame the current address moves to the next valid address. That is the address plus one when it lies inside a configured half-open range, and otherwise the lowest range start above the address. With the default ranges, 0x103 is followed by 0x120.
- R9: When no valid address follows the current one, the current address is held, so 0x140 is followed by 0x140 with the default ranges.
- R10: Words at the end of a frame-data packet that do not complete a frame raise no `out_done` and do not advance the address. The next frame-data packet restarts at index 0 at the same address.
- R11: An identity write whose first word differs from `DEVICE_ID` sets `cfg_bad`. The flag stays set until reset, and a matching identity leaves it unchanged.
- R12: After reset `out_wr`, `out_done` and `cfg_bad` are low, and all registers and the pending-start flag are zero. `in_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat accepted (always high) |
| in_sop | input | 1 | First beat of a packet; opcode and register sampled here |
| in_word | input | 1 | Beat carries a data word (low only on a header-only packet) |
| in_op | input | 2 | Packet opcode |
| in_reg | input | 5 | Packet register address |
| in_data | input | 32 | Data word |
| out_wr | output | 1 | Frame word write strobe |
| out_addr | output | 32 | Frame address of the word |
| out_idx | output | 7 | Word index within the frame |
| out_data | output | 32 | Frame word |
| out_done | output | 1 | Last word of a whole frame |
| cfg_bad | output | 1 | Sticky identity-mismatch flag |

## Verification
The bench drives multi-frame packets that cross a hole between ranges and that run off the end of the last range. An engine that counted addresses linearly would write into the gap, and one that wrapped would jump back to the first range. It sends a frame-address write with the control hold bit set through a full mask and then through a zero mask. This catches a design that ignores the mask, which would rearm the write or fail to rearm it. Partial trailing frames, second words of register packets, header-only packets and non-write opcodes are sent too. Mishandling any of these would show up as a moved address, a missing index restart, or a stray `out_wr` or `cfg_bad`.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
// Shared opcode and register-address encodings for the frame write engine.
package cfgw_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    localparam logic [4:0] RA_FADDR = 5'd1;
    localparam logic [4:0] RA_FDATA = 5'd2;
    localparam logic [4:0] RA_CMD   = 5'd4;
    localparam logic [4:0] RA_MASK  = 5'd6;
    localparam logic [4:0] RA_CTRL  = 5'd8;
    localparam logic [4:0] RA_IDENT = 5'd12;
endpackage

// File: rtl/cfgw_addr_step.sv
`timescale 1ns/1ps
// Next-valid-address logic (combinational).
// Assumes the ranges are half-open [lo, hi) and sorted ascending by lo.
// The result is cur+1 when that lies in a range, else the lowest range start
// above cur, else cur itself.
module cfgw_addr_step #(
    parameter int AW         = 32,
    parameter int MAX_RANGES = 8,
    parameter int NUM_RANGES = 3,
    parameter logic [MAX_RANGES*AW-1:0] RANGE_LO = '0,
    parameter logic [MAX_RANGES*AW-1:0] RANGE_HI = '0
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    logic [AW:0]            inc;
    logic [AW-1:0]          lo_a [NUM_RANGES];
    logic [NUM_RANGES-1:0]  in_rng;
    logic [NUM_RANGES-1:0]  above;

    assign inc = {1'b0, cur} + {{AW{1'b0}}, 1'b1};

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
        logic [AW-1:0] hi_v;
        assign lo_a[i]   = RANGE_LO[i*AW +: AW];
        assign hi_v      = RANGE_HI[i*AW +: AW];
        assign in_rng[i] = (inc >= {1'b0, lo_a[i]}) && (inc < {1'b0, hi_v});
        assign above[i]  = lo_a[i] > cur;
    end

    // Pick the increment, else the first range start above, else hold.
    always_comb begin
        nxt = cur;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (above[i]) nxt = lo_a[i];
        end
        if (|in_rng) nxt = inc[AW-1:0];
    end
endmodule

// File: rtl/cfgw_regs.sv
`timescale 1ns/1ps
// Configuration register file: mask, control, command, frame address,
// pending-start flag and the sticky identity-mismatch flag.
// Assumes wr_en pulses once per write packet, on its first data word.
module cfgw_regs
    import cfgw_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          AW        = 32,
    parameter int          HOLD_BIT  = 21,
    parameter logic [31:0] DEVICE_ID = 32'h00C0_FFEE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [4:0]    wr_reg,
    input  logic [DW-1:0] wr_data,
    input  logic          fd_start,
    output logic [AW-1:0] far_q,
    output logic          pend_q,
    output logic          bad_q
);
    localparam logic [DW-1:0] CMD_WCFG = DW'(1);

    logic [DW-1:0] mask_q;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] cmd_q;

    // Register writes, rearm of the pending start, and its consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctrl_q <= '0;
            cmd_q  <= '0;
            far_q  <= '0;
            pend_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_reg)
                    RA_MASK: mask_q <= wr_data;
                    RA_CTRL: ctrl_q <= wr_data & mask_q;
                    RA_CMD: begin
                        cmd_q <= wr_data;
                        if (wr_data == CMD_WCFG) pend_q <= 1'b1;
                    end
                    RA_FADDR: begin
                        far_q <= wr_data[AW-1:0];
                        if (!ctrl_q[HOLD_BIT] && cmd_q == CMD_WCFG) pend_q <= 1'b1;
                    end
                    RA_IDENT: if (wr_data != DW'(DEVICE_ID)) bad_q <= 1'b1;
                    default: ;
                endcase
            end
            if (fd_start) pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgw_framer.sv
`timescale 1ns/1ps
// Frame grouping: tracks the current address and word index, and emits
// one registered write per frame-data word.
// Assumes nxt_addr is the next valid address after addr_use.
module cfgw_framer #(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int FRAME_WORDS = 101,
    parameter int IDX_W       = $clog2(FRAME_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_fd,
    input  logic             pkt_start,
    input  logic             pend,
    input  logic [AW-1:0]    far,
    input  logic [DW-1:0]    data,
    input  logic [AW-1:0]    nxt_addr,
    output logic [AW-1:0]    addr_use,
    output logic             out_wr,
    output logic [AW-1:0]    out_addr,
    output logic [IDX_W-1:0] out_idx,
    output logic [DW-1:0]    out_data,
    output logic             out_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

    logic [AW-1:0]    cur_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_use;
    logic             last;

    assign addr_use = (pkt_start && pend) ? far : cur_q;
    assign idx_use  = pkt_start ? '0 : idx_q;
    assign last     = idx_use == LAST_IDX;

    // Word emission, index counting and address advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            idx_q    <= '0;
            out_wr   <= 1'b0;
            out_done <= 1'b0;
            out_addr <= '0;
            out_idx  <= '0;
            out_data <= '0;
        end else begin
            out_wr   <= beat_fd;
            out_done <= beat_fd && last;
            if (beat_fd) begin
                out_addr <= addr_use;
                out_idx  <= idx_use;
                out_data <= data;
                idx_q    <= last ? '0 : idx_use + IDX_W'(1);
            end else if (pkt_start) begin
                idx_q <= '0;
            end
            if (pkt_start || beat_fd)
                cur_q <= (beat_fd && last) ? nxt_addr : addr_use;
        end
    end
endmodule

// File: rtl/cfg_frame_writer.sv
`timescale 1ns/1ps
// Configuration frame write engine top.
// Takes decoded packets one word per beat: opcode and register are sampled
// on the start-of-packet beat, which also carries the first word unless
// the packet has none. Never back-pressures.
module cfg_frame_writer
    import cfgw_pkg::*;
#(
    parameter int          DW          = 32,
    parameter int          AW          = 32,
    parameter int          FRAME_WORDS = 101,
    parameter int          HOLD_BIT    = 21,
    parameter logic [31:0] DEVICE_ID   = 32'h00C0_FFEE,
    parameter int          MAX_RANGES  = 8,
    parameter int          NUM_RANGES  = 3,
    parameter logic [MAX_RANGES*AW-1:0] RANGE_LO =
        {160'h0, 32'h0000_0140, 32'h0000_0120, 32'h0000_0100},
    parameter logic [MAX_RANGES*AW-1:0] RANGE_HI =
        {160'h0, 32'h0000_0141, 32'h0000_0128, 32'h0000_0104}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sop,
    input  logic          in_word,
    input  logic [1:0]    in_op,
    input  logic [4:0]    in_reg,
    input  logic [DW-1:0] in_data,
    output logic          out_wr,
    output logic [AW-1:0] out_addr,
    output logic [$clog2(FRAME_WORDS)-1:0] out_idx,
    output logic [DW-1:0] out_data,
    output logic          out_done,
    output logic          cfg_bad
);
    localparam int IDX_W = $clog2(FRAME_WORDS);

    logic          is_wr;
    logic          sop_fd;
    logic          pkt_fd_q;
    logic          cur_fd;
    logic          beat_fd;
    logic          fd_start;
    logic          reg_wr;
    logic [AW-1:0] far_q;
    logic          pend_q;
    logic [AW-1:0] addr_use;
    logic [AW-1:0] nxt_addr;

    assign in_ready = 1'b1;
    assign is_wr    = in_op == OP_WRITE;
    assign sop_fd   = is_wr && in_reg == RA_FDATA;
    assign cur_fd   = in_sop ? sop_fd : pkt_fd_q;
    assign beat_fd  = in_valid && in_word && cur_fd;
    assign fd_start = in_valid && in_sop && sop_fd;
    assign reg_wr   = in_valid && in_sop && in_word && is_wr;

    // Remember whether the packet in flight targets frame data.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pkt_fd_q <= 1'b0;
        else if (in_valid && in_sop) pkt_fd_q <= sop_fd;
    end

    cfgw_regs #(
        .DW(DW), .AW(AW), .HOLD_BIT(HOLD_BIT), .DEVICE_ID(DEVICE_ID)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_reg(in_reg),
        .wr_data(in_data), .fd_start(fd_start),
        .far_q(far_q), .pend_q(pend_q), .bad_q(cfg_bad)
    );

    cfgw_addr_step #(
        .AW(AW), .MAX_RANGES(MAX_RANGES), .NUM_RANGES(NUM_RANGES),
        .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
    ) i_step (
        .cur(addr_use), .nxt(nxt_addr)
    );

    cfgw_framer #(
        .DW(DW), .AW(AW), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)
    ) i_framer (
        .clk(clk), .rst_n(rst_n), .beat_fd(beat_fd), .pkt_start(fd_start),
        .pend(pend_q), .far(far_q), .data(in_data), .nxt_addr(nxt_addr),
        .addr_use(addr_use), .out_wr(out_wr), .out_addr(out_addr),
        .out_idx(out_idx), .out_data(out_data), .out_done(out_done)
    );
endmodule

// File: rtl/cfgw_checker.sv
`timescale 1ns/1ps
// Protocol checks for the frame write engine, bound into the top.
module cfgw_checker
    import cfgw_pkg::*;
#(
    parameter int AW          = 32,
    parameter int FRAME_WORDS = 101,
    parameter int IDX_W       = $clog2(FRAME_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sop,
    input logic [1:0]       in_op,
    input logic             out_wr,
    input logic [AW-1:0]    out_addr,
    input logic [IDX_W-1:0] out_idx,
    input logic             out_done,
    input logic             cfg_bad
);
    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_wr && out_idx == IDX_W'(FRAME_WORDS - 1)); // R7
    AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> out_idx < IDX_W'(FRAME_WORDS)); // R7
    AST_FRAME_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && out_idx != '0) |-> out_addr == $past(out_addr)); // R7
    AST_NONWRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && in_op != OP_WRITE) |=> !out_wr); // R1
    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> cfg_bad); // R11
endmodule

bind cfg_frame_writer cfgw_checker #(
    .AW(AW), .FRAME_WORDS(FRAME_WORDS), .IDX_W(IDX_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_op(in_op), .out_wr(out_wr), .out_addr(out_addr), .out_idx(out_idx),
    .out_done(out_done), .cfg_bad(cfg_bad)
);

// File: tb/test_cfg_frame_writer.sv
`timescale 1ns/1ps
module test_cfg_frame_writer;
    localparam int FW = 101;
    localparam logic [1:0] WR = 2'b10, RD = 2'b01, NOP = 2'b00;
    localparam logic [4:0] FA = 5'd1, FD = 5'd2, CM = 5'd4, MK = 5'd6, CT = 5'd8, ID = 5'd12;
    localparam logic [31:0] GOOD_ID = 32'h00C0_FFEE;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_word = 1'b0;
    logic [1:0] in_op = 2'b00;
    logic [4:0] in_reg = 5'd0;
    logic [31:0] in_data = 32'd0;
    logic in_ready, out_wr, out_done, cfg_bad;
    logic [31:0] out_addr, out_data;
    logic [6:0] out_idx;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_frame_writer i_cfg_frame_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_word(in_word), .in_op(in_op), .in_reg(in_reg),
        .in_data(in_data), .out_wr(out_wr), .out_addr(out_addr),
        .out_idx(out_idx), .out_data(out_data), .out_done(out_done),
        .cfg_bad(cfg_bad)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One beat; outputs sampled 1 ns after the edge that takes it.
    task automatic beat(input bit sop, input bit word, input logic [1:0] op,
                        input logic [4:0] rg, input logic [31:0] d);
        in_valid = 1'b1; in_sop = sop; in_word = word;
        in_op = op; in_reg = rg; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_word = 1'b0;
    endtask

    task automatic wreg(input logic [4:0] rg, input logic [31:0] d);
        beat(1'b1, 1'b1, WR, rg, d);
        check(!out_wr, "R2 register write makes no frame word", {31'd0, out_wr}, 32'd0);
    endtask

    // Frame-data packet of n words; frame f is expected at addresses a[f].
    task automatic send_fd(input int n, input logic [31:0] a0, input logic [31:0] a1,
                           input logic [31:0] a2, input string req);
        logic [31:0] exp_a;
        for (int k = 0; k < n; k++) begin
            beat(k == 0, 1'b1, WR, FD, 32'h5A00_0000 + k);
            exp_a = (k / FW == 0) ? a0 : (k / FW == 1) ? a1 : a2;
            check(out_wr && out_addr == exp_a, req, out_addr, exp_a);
            check(out_idx == 7'(k % FW), {req, " R7 index"}, {25'd0, out_idx}, k % FW);
            check(out_done == (k % FW == FW - 1), {req, " R7 done"}, {31'd0, out_done}, {31'd0, k % FW == FW - 1});
            check(out_data == 32'h5A00_0000 + k, {req, " R7 data"}, out_data, 32'h5A00_0000 + k);
        end
    endtask

    task automatic t_reset();
        check(!out_wr && !out_done, "R12 outputs idle after reset", {30'd0, out_wr, out_done}, 32'd0);
        check(!cfg_bad, "R12 cfg_bad low after reset", {31'd0, cfg_bad}, 32'd0);
        check(in_ready, "R12 in_ready high", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_single();
        wreg(ID, GOOD_ID);
        check(!cfg_bad, "R11 matching identity", {31'd0, cfg_bad}, 32'd0);
        wreg(CM, 32'd1);
        wreg(FA, 32'h101);
        send_fd(FW, 32'h101, 0, 0, "R4 R6 single frame at loaded address");
    endtask

    task automatic t_continue();
        send_fd(FW, 32'h102, 0, 0, "R8 next packet continues at incremented address");
    endtask

    task automatic t_gap();
        wreg(FA, 32'h103);
        send_fd(2 * FW, 32'h103, 32'h120, 0, "R5 R8 rearm and skip range gap");
    endtask

    task automatic t_end();
        wreg(FA, 32'h140);
        send_fd(2 * FW, 32'h140, 32'h140, 0, "R9 address held past last range");
    endtask

    task automatic t_partial();
        wreg(FA, 32'h121);
        send_fd(50, 32'h121, 0, 0, "R10 partial frame words");
        send_fd(FW, 32'h121, 0, 0, "R10 restart at index 0 same address");
    endtask

    task automatic t_ignore();
        beat(1'b1, 1'b1, RD, FA, 32'h100);
        check(!out_wr, "R1 read opcode quiet", {31'd0, out_wr}, 0);
        beat(1'b1, 1'b1, RD, ID, 32'hDEAD_BEEF);
        check(!cfg_bad, "R1 read of wrong identity ignored", {31'd0, cfg_bad}, 0);
        for (int k = 0; k < 5; k++) begin
            beat(k == 0, 1'b1, NOP, FD, 32'h1);
            check(!out_wr, "R1 nop frame data produces no write", {31'd0, out_wr}, 0);
        end
        beat(1'b1, 1'b0, WR, FA, 32'h0);           // header-only: no word
        beat(1'b1, 1'b1, WR, FA, 32'h123);
        beat(1'b0, 1'b1, WR, FA, 32'h100);         // second word: unused
        send_fd(FW, 32'h123, 0, 0, "R2 first word only, R1 nothing else applied");
    endtask

    task automatic t_ctrl_mask();
        wreg(CT, 32'h0020_0000);                   // mask zero: stored as 0
        wreg(FA, 32'h125);
        send_fd(FW, 32'h125, 0, 0, "R3 control masked to zero, rearm kept");
        wreg(MK, 32'hFFFF_FFFF);
        wreg(CT, 32'h0020_0000);
        wreg(FA, 32'h101);
        send_fd(FW, 32'h126, 0, 0, "R5 hold bit suppresses rearm");
        wreg(CM, 32'd1);
        send_fd(FW, 32'h101, 0, 0, "R4 command write rearms");
    endtask

    task automatic t_ident();
        wreg(ID, 32'h0BAD_0001);
        check(cfg_bad, "R11 mismatch sets cfg_bad", {31'd0, cfg_bad}, 1);
        wreg(ID, GOOD_ID);
        check(cfg_bad, "R11 cfg_bad sticky", {31'd0, cfg_bad}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_single();
        t_continue();
        t_gap();
        t_end();
        t_partial();
        t_ignore();
        t_ctrl_mask();
        t_ident();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule